// File: doc/BRIEF.md
# Network Reconfiguration Timeout Timer

This block watches a token-passing network node for a lack of activity. It counts time from the last activity the node observed. If that time grows past a chosen limit, the block decides the token has been lost and emits a one-cycle reconfiguration request. Every valid frame or token the surrounding logic observes arrives as a restart pulse and starts the count again from zero.

A two-bit mode field selects one of four limits. The limits stand in the ratio 16 : 4 : 2 : 1 of a base unit. A shorter limit brings the network back sooner after a fault, but it only suits smaller networks. The shortest setting assumes the node with the highest address is on the network.

A three-bit rate field stretches every limit by a power of two, from 1 to 64. This keeps the limits correct when the network runs at a lower data rate. Mode and rate are latched only when a count begins, so a change made while counting waits for the next start.

The controller has four named states:
- OFF: the timer is disabled.
- LOAD: the mode and rate are latched and the counters are cleared.
- RUN: the timer is counting.
- FIRE: the timeout pulse is emitted.

The transitions are:
- OFF to LOAD when enabled.
- Any state to OFF when the enable is low.
- LOAD to RUN always.
- RUN to LOAD on a restart pulse.
- RUN to FIRE on the last tick of the interval.
- FIRE to LOAD always, which is the automatic restart.

Top module: `recon_timer`

## Requirements
- R1: While reset is high and on the cycle after it, `timeout_o` is low, and both counters are cleared.
- R2: Let D be the cycles per base tick after rate scaling. The interval length N is counted in base ticks of D cycles. N is 16·UNIT for mode 0, 4·UNIT for mode 1, 2·UNIT for mode 2 and UNIT for mode 3.
- R3: D is TICK_CYC·2^r for rate value r from 0 to 6. Rate value 7 is treated as 6, so D is TICK_CYC·64.
- R4: `timeout_o` is high for exactly one cycle per expiry.
- R5: After a pulse the count reloads by itself, so consecutive pulses with no restart are N·D+2 cycles apart.
- R6: A restart pulse sampled while enabled restarts the count. The next pulse comes N·D+1 cycles after the edge that sampled the restart, and no pulse occurs on the cycle after a restart.
- R7: A change to `mode_i` or `rate_i` while counting does not alter the current interval. It applies from the next reload.
- R8: While `en_i` is low, no pulse is produced and the count is held cleared.
- R9: After `en_i` rises, the first pulse comes N·D+1 cycles after the edge that samples the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Timer enable |
| restart_i | input | 1 | Activity seen; restarts the count |
| mode_i | input | 2 | Timeout length select |
| rate_i | input | 3 | Data-rate scale, divisor 2^value (7 acts as 6) |
| timeout_o | output | 1 | One-cycle reconfiguration request |

## Verification
The bench builds the timer with TICK_CYC = 2 and UNIT = 3. The longest interval is then 48 ticks of at most 128 cycles, so every mode, every rate and the clamped rate value reach expiry within a few thousand cycles. These small values also make the exact cycle of each pulse easy to predict.

The bench checks the first-pulse latency and the reload period for each setting. It also checks that a mode change made mid-interval applies only from the next interval. Finally, it checks that repeated restarts and a low enable suppress the pulse entirely.

// File: rtl/rcn_pkg.sv
package rcn_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_LOAD = 2'd1,
        ST_RUN  = 2'd2,
        ST_FIRE = 2'd3
    } rcn_state_e;

    // Rate value 7 falls back to the slowest supported divisor (2^6).
    function automatic logic [2:0] rate_clamp(input logic [2:0] r);
        return (r == 3'd7) ? 3'd6 : r;
    endfunction

    // Mode to left shift of the base unit: 16, 4, 2, 1 units.
    function automatic logic [2:0] mode_shift(input logic [1:0] m);
        logic [2:0] s;
        unique case (m)
            2'd0: s = 3'd4;
            2'd1: s = 3'd2;
            2'd2: s = 3'd1;
            2'd3: s = 3'd0;
            default: s = 3'd0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/rcn_prescale.sv
module rcn_prescale #(
    parameter  int TICK_CYC = 20,
    localparam int PW       = $clog2(TICK_CYC * 64 + 1)
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       clr_i,
    input  logic       run_i,
    input  logic [2:0] exp_i,
    output logic       tick_o
);

    logic [PW-1:0] cnt;
    logic [PW-1:0] lim;

    always_comb begin
        lim    = (PW'(TICK_CYC) << exp_i) - PW'(1);
        tick_o = run_i && (cnt == lim);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i || clr_i) begin
            cnt <= '0;
        end else if (run_i) begin
            cnt <= tick_o ? '0 : cnt + PW'(1);
        end
    end

endmodule

// File: rtl/rcn_interval.sv
module rcn_interval #(
    parameter  int UNIT = 13125,
    localparam int NW   = $clog2(UNIT * 16 + 1)
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       clr_i,
    input  logic       tick_i,
    input  logic [2:0] shift_i,
    output logic       last_o
);

    logic [NW-1:0] cnt;
    logic [NW-1:0] lim;

    always_comb begin
        lim    = (NW'(UNIT) << shift_i) - NW'(1);
        last_o = tick_i && (cnt == lim);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i || clr_i) begin
            cnt <= '0;
        end else if (tick_i) begin
            cnt <= last_o ? '0 : cnt + NW'(1);
        end
    end

endmodule

// File: rtl/rcn_ctrl.sv
module rcn_ctrl
    import rcn_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       en_i,
    input  logic       restart_i,
    input  logic [1:0] mode_i,
    input  logic [2:0] rate_i,
    input  logic       last_i,
    output logic       clr_o,
    output logic       run_o,
    output logic [2:0] shift_o,
    output logic [2:0] exp_o,
    output logic       timeout_o
);

    rcn_state_e state_q, state_d;
    logic [2:0] lat_shift, lat_exp;

    // State register and settings latch
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q   <= ST_OFF;
            lat_shift <= 3'd0;
            lat_exp   <= 3'd0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_LOAD) begin
                lat_shift <= mode_shift(mode_i);
                lat_exp   <= rate_clamp(rate_i);
            end
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (!en_i) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:  state_d = ST_LOAD;
                ST_LOAD: state_d = ST_RUN;
                ST_RUN: begin
                    if (restart_i)   state_d = ST_LOAD;
                    else if (last_i) state_d = ST_FIRE;
                end
                ST_FIRE: state_d = ST_LOAD;
                default: state_d = ST_OFF;
            endcase
        end
    end

    // Outputs
    always_comb begin
        clr_o     = (state_q != ST_RUN);
        run_o     = (state_q == ST_RUN);
        timeout_o = (state_q == ST_FIRE);
        shift_o   = lat_shift;
        exp_o     = lat_exp;
    end

endmodule

// File: rtl/recon_timer.sv
module recon_timer #(
    parameter int TICK_CYC = 20,
    parameter int UNIT     = 13125
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       en_i,
    input  logic       restart_i,
    input  logic [1:0] mode_i,
    input  logic [2:0] rate_i,
    output logic       timeout_o
);

    logic       clr, run, tick, last;
    logic [2:0] shift, expo;

    rcn_ctrl u_ctrl (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .en_i      (en_i),
        .restart_i (restart_i),
        .mode_i    (mode_i),
        .rate_i    (rate_i),
        .last_i    (last),
        .clr_o     (clr),
        .run_o     (run),
        .shift_o   (shift),
        .exp_o     (expo),
        .timeout_o (timeout_o)
    );

    rcn_prescale #(.TICK_CYC(TICK_CYC)) u_pre (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .clr_i  (clr),
        .run_i  (run),
        .exp_i  (expo),
        .tick_o (tick)
    );

    rcn_interval #(.UNIT(UNIT)) u_ivl (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .clr_i   (clr),
        .tick_i  (tick),
        .shift_i (shift),
        .last_o  (last)
    );

endmodule

// File: rtl/recon_timer_chk.sv
module recon_timer_chk (
    input logic clk_i,
    input logic rst_i,
    input logic en_i,
    input logic restart_i,
    input logic timeout_o
);

    AST_RESET_QUIET: assert property (@(posedge clk_i) rst_i |=> !timeout_o); // R1

    AST_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (rst_i)
        timeout_o |=> !timeout_o); // R4

    AST_RELOAD_GAP: assert property (@(posedge clk_i) disable iff (rst_i)
        timeout_o |=> ##1 !timeout_o); // R5

    AST_RESTART_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
        restart_i |=> !timeout_o); // R6

    AST_DISABLED_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> !timeout_o); // R8

endmodule

bind recon_timer recon_timer_chk u_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .en_i      (en_i),
    .restart_i (restart_i),
    .timeout_o (timeout_o)
);

// File: tb/recon_timer_tb.sv
`timescale 1ns/1ps
module recon_timer_tb;

    localparam int NV = 10;
    // Expected cycles to first pulse = N*D+1 with TICK_CYC=2, UNIT=3
    localparam int V_MODE [NV] = '{0, 1, 2, 3, 3, 2, 1, 3, 3, 0};
    localparam int V_RATE [NV] = '{0, 0, 0, 0, 1, 3, 5, 6, 7, 2};
    localparam int V_EXP  [NV] = '{97, 25, 13, 7, 13, 97, 769, 385, 385, 385};

    logic       clk = 1'b0;
    logic       rst_i = 1'b1;
    logic       en_i = 1'b0;
    logic       restart_i = 1'b0;
    logic [1:0] mode_i = 2'd3;
    logic [2:0] rate_i = 3'd0;
    logic       timeout_o;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    recon_timer #(.TICK_CYC(2), .UNIT(3)) u_dut (
        .clk_i     (clk),
        .rst_i     (rst_i),
        .en_i      (en_i),
        .restart_i (restart_i),
        .mode_i    (mode_i),
        .rate_i    (rate_i),
        .timeout_o (timeout_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wait_pulse(output int n, input int lim);
        bit found = 1'b0;
        n = 0;
        while (!found && n < lim) begin
            step();
            n++;
            if (timeout_o) found = 1'b1;
        end
        if (!found) n = -1;
    endtask

    task automatic do_restart();
        restart_i = 1'b1;
        step();
        restart_i = 1'b0;
    endtask

    task automatic count_pulses(input int cyc, output int p);
        p = 0;
        for (int k = 0; k < cyc; k++) begin
            step();
            if (timeout_o) p++;
        end
    endtask

    initial begin
        int n, p;
        // R1: reset holds output low
        for (int k = 0; k < 5; k++) begin
            step();
            chk("R1 reset low", int'(timeout_o), 0);
        end
        rst_i = 1'b0;
        // R8: disabled stays quiet
        count_pulses(100, p);
        chk("R8 disabled pulses", p, 0);

        // R9: first pulse after enable
        mode_i = 2'd3; rate_i = 3'd0;
        en_i = 1'b1;
        step();
        wait_pulse(n, 200);
        chk("R9 first pulse after enable", n, 7);

        // Table: R2 R3 latency, R4 width, R5 period
        for (int i = 0; i < NV; i++) begin
            mode_i = V_MODE[i][1:0];
            rate_i = V_RATE[i][2:0];
            do_restart();
            wait_pulse(n, V_EXP[i] + 50);
            chk($sformatf("R2 R3 R6 latency vec%0d", i), n, V_EXP[i]);
            step();
            chk($sformatf("R4 pulse width vec%0d", i), int'(timeout_o), 0);
            wait_pulse(n, V_EXP[i] + 50);
            chk($sformatf("R5 period vec%0d", i), n + 1, V_EXP[i] + 1);
        end

        // R7: mid-interval mode change applies at next reload
        mode_i = 2'd3; rate_i = 3'd0;
        do_restart();
        step(); step();
        mode_i = 2'd0;
        wait_pulse(n, 200);
        chk("R7 current interval unchanged", n, 5);
        wait_pulse(n, 300);
        chk("R7 new mode after reload", n, 98);

        // R8: disable mid-count, then fresh start
        mode_i = 2'd3; rate_i = 3'd2;
        do_restart();
        for (int k = 0; k < 10; k++) step();
        en_i = 1'b0;
        count_pulses(100, p);
        chk("R8 no pulse while disabled", p, 0);
        rate_i = 3'd0;
        en_i = 1'b1;
        step();
        wait_pulse(n, 200);
        chk("R8 fresh count after re-enable", n, 7);

        // R6: frequent restarts suppress the pulse
        p = 0;
        for (int r = 0; r < 10; r++) begin
            restart_i = 1'b1;
            step();
            restart_i = 1'b0;
            if (timeout_o) p++;
            for (int k = 0; k < 4; k++) begin
                step();
                if (timeout_o) p++;
            end
        end
        chk("R6 restarts suppress pulse", p, 0);
        do_restart();
        wait_pulse(n, 200);
        chk("R6 pulse after last restart", n, 7);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule